// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block keeps a clock and calendar in eight byte-wide registers, all in packed BCD. It counts seconds, minutes and hours (24-hour), the day of the week, the day of the month, the month and a two-digit year. A century flag can toggle when the year wraps. An eighth byte holds control bits. The block does not act on the control byte; it only stores it for logic elsewhere.

The block divides an incoming sub-second pulse by a parameter to make its one-second step. A host reads and writes the registers through a simple synchronous port. A halt bit freezes the time. A sticky flag records oscillator trouble that is reported on an input.

A read of address 0 copies every register into a shadow image. Reads of the other addresses return bytes from that image. The host therefore sees one coherent moment even if a second boundary falls between its reads.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset the registers read: address 0 = 00h, 1 = 80h (fail flag set), 2 = 00h, 3 = 01h, 4 = 01h, 5 = 01h, 6 = 00h, 7 = 00h.
- R2: Field positions are as follows. Address 0 holds the halt bit in bit 7 and the seconds in bits 6..0. Address 1 holds the fail flag in bit 7 and the minutes in bits 6..0. Address 2 holds the century enable in bit 7, the century flag in bit 6 and the hours in bits 5..0. Address 3 holds the weekday in bits 2..0. Address 4 holds the date in bits 5..0. Address 5 holds the month in bits 4..0. Address 6 holds the year in bits 7..0. Bits outside these fields are dropped on write and read as 0.
- R3: One second elapses after SUB_TICKS sub-second pulses. Any register write restarts that count, so the next step comes SUB_TICKS pulses after the write.
- R4: On each step, seconds count 00..59 and then wrap, carrying into minutes. Minutes count 00..59 and carry into hours. Hours count 00..23 and carry into the day.
- R5: While the halt bit is 1, steps are ignored and the time stays as it is.
- R6: At each midnight carry the weekday goes from 7 to 1 and otherwise increments by 1.
- R7: The date wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 otherwise. All other months have 31 days.
- R8: After month 12 the month wraps to 01 and the year increments. When the year wraps from 99 to 00, the century flag toggles if the century enable bit is 1 and holds if it is 0.
- R9: A pulse on osc_fail_evt sets the fail flag. A host write of 0 to that bit clears it; a write of 1 leaves it as it is. When a pulse and a clearing write land in the same cycle, the pulse wins.
- R10: rd_data is valid in the cycle after rd_en. Reading address 0 returns the live byte and captures all eight registers. Reading any other address returns that byte from the last capture.
- R11: Address 7 stores all eight written bits unchanged and has no effect on timekeeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | Sub-second pulse, one cycle wide |
| osc_fail_evt | input | 1 | Oscillator trouble pulse; sets the fail flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |

## Verification
The bench walks a full hour second by second and every hour boundary of a day. It also walks every month end in both a leap year and a common year. A design with a binary rather than decimal carry, or with a wrong month length, would read back 0x5A seconds, day 0x32 or a missing February 29th. The bench sets a year of 99 with the century enable both on and off, which exposes a century flag that never toggles or toggles regardless of the enable. It also writes a register partway through a second, which catches a prescaler that keeps its old count. Finally it reads minutes across a carry after capturing, which shows whether reads tear or come from the snapshot.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_COUNT = 8;
    localparam int ADDR_W    = $clog2(REG_COUNT);

    typedef struct packed {
        logic       halt;
        logic [6:0] sec;
        logic       fail;
        logic [6:0] min;
        logic       cen_en;
        logic       cen;
        logic [5:0] hour;
        logic [2:0] wday;
        logic [5:0] mday;
        logic [4:0] mon;
        logic [7:0] year;
        logic [7:0] ctrl;
    } rtc_time_t;

    // Increment a two-digit packed BCD value, units carry at 9.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = v + 8'd1;
        return r;
    endfunction

    // Byte image of one register, unused bits forced to zero.
    function automatic logic [7:0] reg_image(input rtc_time_t t, input logic [ADDR_W-1:0] a);
        logic [7:0] b;
        case (a)
            3'd0:    b = {t.halt, t.sec};
            3'd1:    b = {t.fail, t.min};
            3'd2:    b = {t.cen_en, t.cen, t.hour};
            3'd3:    b = {5'd0, t.wday};
            3'd4:    b = {2'd0, t.mday};
            3'd5:    b = {3'd0, t.mon};
            3'd6:    b = t.year;
            default: b = t.ctrl;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int SUB_TICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_tick,
    input  logic restart,
    output logic sec_pulse
);
    localparam int CW = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SUB_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        sec_pulse = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (sub_tick) begin
            if (cnt_q == LAST) begin
                cnt_d     = '0;
                sec_pulse = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [4:0] mon,
    input  logic [7:0] year,
    output logic [5:0] last_day
);
    logic leap;

    always_comb begin
        // Divisible by 4 in BCD: even tens with units 0/4/8, odd tens with units 2/6.
        if (year[4]) leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        else         leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
        case (mon)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic [5:0] last_day;
    logic       sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap, year_wrap;

    rtc_month_len u_len (
        .mon      (cur.mon),
        .year     (cur.year),
        .last_day (last_day)
    );

    always_comb begin
        nxt       = cur;
        sec_wrap  = cur.sec  >= 7'h59;
        min_wrap  = cur.min  >= 7'h59;
        hour_wrap = cur.hour >= 6'h23;
        day_wrap  = cur.mday >= last_day;
        mon_wrap  = cur.mon  >= 5'h12;
        year_wrap = cur.year >= 8'h99;

        nxt.sec = sec_wrap ? 7'h00 : 7'(bcd_inc({1'b0, cur.sec}));
        if (sec_wrap) begin
            nxt.min = min_wrap ? 7'h00 : 7'(bcd_inc({1'b0, cur.min}));
            if (min_wrap) begin
                nxt.hour = hour_wrap ? 6'h00 : 6'(bcd_inc({2'b0, cur.hour}));
                if (hour_wrap) begin
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    nxt.mday = day_wrap ? 6'h01 : 6'(bcd_inc({2'b0, cur.mday}));
                    if (day_wrap) begin
                        nxt.mon = mon_wrap ? 5'h01 : 5'(bcd_inc({3'b0, cur.mon}));
                        if (mon_wrap) begin
                            nxt.year = year_wrap ? 8'h00 : bcd_inc(cur.year);
                            if (year_wrap && cur.cen_en) nxt.cen = ~cur.cen;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
    import rtc_pkg::*;
#(
    parameter int SUB_TICKS = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic       osc_fail_evt,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    typedef struct packed {
        rtc_time_t                     tm;
        logic [REG_COUNT-1:0][7:0]     snap;
        logic [7:0]                    rd;
    } state_t;

    state_t    s_d, s_q;
    rtc_time_t adv_tm;
    logic      sec_pulse;

    // Observation points for the bound checker.
    logic       halt_live;
    logic       fail_live;
    logic [6:0] sec_live;

    rtc_prescaler #(.SUB_TICKS(SUB_TICKS)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_tick  (sub_tick),
        .restart   (wr_en),
        .sec_pulse (sec_pulse)
    );

    rtc_advance u_adv (
        .cur (s_q.tm),
        .nxt (adv_tm)
    );

    always_comb begin
        s_d = s_q;
        if (sec_pulse && !s_q.tm.halt) s_d.tm = adv_tm;

        if (wr_en) begin
            case (addr)
                3'd0: begin
                    s_d.tm.halt = wr_data[7];
                    s_d.tm.sec  = wr_data[6:0];
                end
                3'd1: begin
                    if (!wr_data[7]) s_d.tm.fail = 1'b0;
                    s_d.tm.min = wr_data[6:0];
                end
                3'd2: begin
                    s_d.tm.cen_en = wr_data[7];
                    s_d.tm.cen    = wr_data[6];
                    s_d.tm.hour   = wr_data[5:0];
                end
                3'd3:    s_d.tm.wday = wr_data[2:0];
                3'd4:    s_d.tm.mday = wr_data[5:0];
                3'd5:    s_d.tm.mon  = wr_data[4:0];
                3'd6:    s_d.tm.year = wr_data;
                default: s_d.tm.ctrl = wr_data;
            endcase
        end

        if (osc_fail_evt) s_d.tm.fail = 1'b1;

        if (rd_en) begin
            if (addr == 3'd0) begin
                for (int i = 0; i < REG_COUNT; i++) begin
                    s_d.snap[i] = reg_image(s_q.tm, ADDR_W'(i));
                end
                s_d.rd = reg_image(s_q.tm, 3'd0);
            end else begin
                s_d.rd = s_q.snap[addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.tm.fail <= 1'b1;
            s_q.tm.wday <= 3'd1;
            s_q.tm.mday <= 6'h01;
            s_q.tm.mon  <= 5'h01;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data   = s_q.rd;
    assign halt_live = s_q.tm.halt;
    assign fail_live = s_q.tm.fail;
    assign sec_live  = s_q.tm.sec;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
    parameter int SUB_TICKS = 32768
) (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_fail_evt,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic       wr_fail_bit,
    input logic [7:0] rd_data,
    input logic       sec_pulse,
    input logic       halt_live,
    input logic       fail_live,
    input logic [6:0] sec_live
);
    // R5: halted time does not move unless the host writes.
    a_r5_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_live && !wr_en) |=> $stable(sec_live));

    // R9: a fail pulse always leaves the flag set.
    a_r9_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fail_evt |=> fail_live);

    // R9: only a write of 0 to the flag bit clears it.
    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_live && !(wr_en && addr == 3'd1 && !wr_fail_bit)) |=> fail_live);

    // R3: a write restarts the second, so no step follows right after it.
    a_r3_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        ((SUB_TICKS > 1) && wr_en) |=> !sec_pulse);

    // R10: reading address 0 returns the live seconds byte one cycle later.
    a_r10_live_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd0) |=> rd_data == {$past(halt_live), $past(sec_live)});

    // R4: an unhalted step with no write changes the seconds.
    a_r4_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !halt_live && !wr_en) |=> !$stable(sec_live));
endmodule

bind rtc_calendar_regs rtc_calendar_chk #(.SUB_TICKS(SUB_TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_fail_evt (osc_fail_evt),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wr_fail_bit  (wr_data[7]),
    .rd_data      (rd_data),
    .sec_pulse    (sec_pulse),
    .halt_live    (halt_live),
    .fail_live    (fail_live),
    .sec_live     (sec_live)
);

// File: tb/tb_rtc_calendar_regs.sv
module tb_rtc_calendar_regs;
    localparam int SUBS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       osc_fail_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    rtc_calendar_regs #(.SUB_TICKS(SUBS)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sub_tick     (sub_tick),
        .osc_fail_evt (osc_fail_evt),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [7:0] bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic subs(input int n);
        if (n > 0) begin
            @(negedge clk);
            sub_tick = 1'b1;
            repeat (n - 1) @(negedge clk);
            @(negedge clk);
            sub_tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] y, input logic [7:0] m, input logic [7:0] d,
                            input logic [7:0] w, input logic [7:0] h, input logic [7:0] mi,
                            input logic [7:0] s);
        wr(3'd6, y); wr(3'd5, m); wr(3'd4, d); wr(3'd3, w);
        wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset image
        rd(3'd0, v); chk("R1 addr0", v, 8'h00);
        rd(3'd1, v); chk("R1 addr1", v, 8'h80);
        rd(3'd2, v); chk("R1 addr2", v, 8'h00);
        rd(3'd3, v); chk("R1 addr3", v, 8'h01);
        rd(3'd4, v); chk("R1 addr4", v, 8'h01);
        rd(3'd5, v); chk("R1 addr5", v, 8'h01);
        rd(3'd6, v); chk("R1 addr6", v, 8'h00);
        rd(3'd7, v); chk("R1 addr7", v, 8'h00);

        // R2, R11: masks and plain control byte
        for (int a = 0; a < 8; a++) wr(3'(a), 8'hFF);
        rd(3'd0, v); chk("R2 addr0", v, 8'hFF);
        rd(3'd1, v); chk("R2 addr1", v, 8'hFF);
        rd(3'd2, v); chk("R2 addr2", v, 8'hFF);
        rd(3'd3, v); chk("R2 addr3", v, 8'h07);
        rd(3'd4, v); chk("R2 addr4", v, 8'h3F);
        rd(3'd5, v); chk("R2 addr5", v, 8'h1F);
        rd(3'd6, v); chk("R2 addr6", v, 8'hFF);
        rd(3'd7, v); chk("R11 addr7", v, 8'hFF);
        wr(3'd7, 8'hA5);
        rd(3'd0, v); rd(3'd7, v); chk("R11 ctrl", v, 8'hA5);

        // R5: halted clock ignores steps
        wr(3'd0, 8'h80 | 8'h12);
        subs(3 * SUBS);
        rd(3'd0, v); chk("R5 halted", v, 8'h92);
        wr(3'd0, 8'h12);
        subs(SUBS);
        rd(3'd0, v); chk("R5 resumed", v, 8'h13);

        // R9: fail flag
        wr(3'd1, 8'h80 | 8'h07);
        rd(3'd0, v); rd(3'd1, v); chk("R9 write1 keeps", v, 8'h87);
        wr(3'd1, 8'h07);
        rd(3'd0, v); rd(3'd1, v); chk("R9 write0 clears", v, 8'h07);
        @(negedge clk); osc_fail_evt = 1'b1;
        @(negedge clk); osc_fail_evt = 1'b0;
        rd(3'd0, v); rd(3'd1, v); chk("R9 pulse sets", v, 8'h87);
        @(negedge clk);
        osc_fail_evt = 1'b1; wr_en = 1'b1; addr = 3'd1; wr_data = 8'h07;
        @(negedge clk);
        osc_fail_evt = 1'b0; wr_en = 1'b0;
        rd(3'd0, v); rd(3'd1, v); chk("R9 pulse wins", v, 8'h87);
        wr(3'd1, 8'h07);

        // R3: write restarts the second
        wr(3'd0, 8'h00);
        subs(SUBS - 1);
        wr(3'd7, 8'h00);
        subs(SUBS - 1);
        rd(3'd0, v); chk("R3 restarted", v, 8'h00);
        subs(1);
        rd(3'd0, v); chk("R3 full second", v, 8'h01);

        // R10: snapshot coherence
        wr(3'd1, 8'h10); wr(3'd0, 8'h59);
        rd(3'd0, v); chk("R10 live", v, 8'h59);
        subs(SUBS);
        rd(3'd1, v); chk("R10 snapshot", v, 8'h10);
        rd(3'd0, v); chk("R10 live after", v, 8'h00);
        rd(3'd1, v); chk("R10 recaptured", v, 8'h11);

        // R4: one full hour second by second
        set_time(8'h24, 8'h01, 8'h01, 8'h01, 8'h05, 8'h00, 8'h00);
        for (int s = 1; s <= 3600; s++) begin
            subs(SUBS);
            rd(3'd0, v); chk("R4 seconds", v, bcd(s % 60));
            rd(3'd1, v); chk("R4 minutes", v, bcd((s / 60) % 60));
        end
        rd(3'd2, v); chk("R4 hour carry", v, 8'h06);

        // R4, R6: every hour boundary of a day
        for (int h = 0; h < 24; h++) begin
            set_time(8'h24, 8'h03, 8'h10, 8'h07, bcd(h), 8'h59, 8'h59);
            subs(SUBS);
            rd(3'd0, v); chk("R4 sec wrap", v, 8'h00);
            rd(3'd1, v); chk("R4 min wrap", v, 8'h00);
            rd(3'd2, v); chk("R4 hour", v, bcd((h + 1) % 24));
            rd(3'd3, v); chk("R6 weekday", v, (h == 23) ? 8'h01 : 8'h07);
            rd(3'd4, v); chk("R7 date hold", v, (h == 23) ? 8'h11 : 8'h10);
        end
        set_time(8'h24, 8'h03, 8'h10, 8'h03, 8'h23, 8'h59, 8'h59);
        subs(SUBS);
        rd(3'd0, v); rd(3'd3, v); chk("R6 weekday step", v, 8'h04);

        // R7, R8: every month end, common and leap year
        for (int yi = 0; yi < 2; yi++) begin
            for (int m = 1; m <= 12; m++) begin
                int y;
                int n;
                y = (yi == 0) ? 23 : 24;
                n = mlen(m, y);
                set_time(bcd(y), bcd(m), bcd(n - 1), 8'h02, 8'h23, 8'h59, 8'h59);
                subs(SUBS);
                rd(3'd0, v); rd(3'd4, v); chk("R7 day before end", v, bcd(n));
                set_time(bcd(y), bcd(m), bcd(n), 8'h02, 8'h23, 8'h59, 8'h59);
                subs(SUBS);
                rd(3'd0, v);
                rd(3'd4, v); chk("R7 date wrap", v, 8'h01);
                rd(3'd5, v); chk("R8 month", v, bcd((m % 12) + 1));
                rd(3'd6, v); chk("R8 year", v, bcd((m == 12) ? y + 1 : y));
            end
        end

        // R8: century with enable on and off
        set_time(8'h99, 8'h12, 8'h31, 8'h01, 8'h80 | 8'h23, 8'h59, 8'h59);
        subs(SUBS);
        rd(3'd0, v);
        rd(3'd2, v); chk("R8 century toggles", v, 8'hC0);
        rd(3'd6, v); chk("R8 year wrap", v, 8'h00);
        rd(3'd5, v); chk("R8 month wrap", v, 8'h01);
        set_time(8'h99, 8'h12, 8'h31, 8'h01, 8'h40 | 8'h23, 8'h59, 8'h59);
        subs(SUBS);
        rd(3'd0, v);
        rd(3'd2, v); chk("R8 century held", v, 8'h40);
        rd(3'd6, v); chk("R8 year wrap off", v, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule